// File: doc/BRIEF.md
# Burst Address Sequencer

This block keeps the address of a synchronous burst memory and walks it through a burst of four beats. An external address is captured whenever either of two load strobes is high at a rising clock edge. After that, each cycle with the advance input high moves to the next beat. Only the low two address bits take part in the burst. The upper bits stay where the load put them.

A mode input picks how the low bits are visited. In linear order they count up by one and wrap from 3 back to 0. In interleaved order each beat address is the starting low bits XORed with the count of beats taken so far. Interleaved order is selected by the low level, so a mode input tied low gives the default order.

Bursting is optional. A new external address can be loaded on every cycle without losing a cycle. A load beats advance when both arrive together, and with no strobe and no advance the address stays as it is.

Top module: `burst_addr_seq`

## Requirements
- R1: When rst_n is low at a rising edge, burst_addr becomes 0 after that edge.
- R2: If ld_a or ld_b is high at a rising edge, burst_addr equals the ext_addr sampled at that edge after the edge. The two strobes behave identically.
- R3: If adv is high and both strobes are low at an edge, only the low 2 bits of burst_addr may change. The upper bits keep their value.
- R4: With order_lin = 1 (linear), each advance adds 1 to the low 2 bits, modulo 4, so the sequence wraps from 3 to 0.
- R5: With order_lin = 0 (interleaved), the low 2 bits after k advances since a load equal the loaded low bits XOR (k mod 4). From start 1 this gives 1, 0, 3, 2.
- R6: After four advances in either order, the low bits are back at the loaded start value. Further advances repeat the same cycle.
- R7: When a strobe and adv are high at the same edge, the load wins and burst_addr takes ext_addr. That load restarts the beat count at 0.
- R8: If no strobe and no adv are high at an edge, burst_addr keeps its value.
- R9: Loads on consecutive cycles each take effect, one per cycle, with no idle cycle needed between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_addr | input | ADDR_W | Address offered for loading |
| ld_a | input | 1 | First load strobe |
| ld_b | input | 1 | Second load strobe |
| adv | input | 1 | Step to the next beat of the burst |
| order_lin | input | 1 | 1 = linear order, 0 = interleaved order (default) |
| burst_addr | output | ADDR_W | Registered current burst address |

## Verification
Every starting low-bit value is loaded in both orders, through each strobe and with two different upper-bit patterns. Each load is followed by six advances. Six advances go past the four-beat wrap, so the sweep separates a linear adder from an XOR mapping and from a counter that is not cleared or that carries into the upper bits. Idle cycles within a burst show whether the address holds and whether the beat count drifts. A strobe given together with advance, and loads on back-to-back cycles, show whether the load takes priority and whether any cycle is lost between loads.

// File: rtl/burst_seq_pkg.sv
// Package: burst_seq_pkg
// Shared types for the burst address sequencer.
// Assumes: the consumers agree on the action encoding below.
package burst_seq_pkg;

    // Per-cycle decision taken by the load controller.
    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_LOAD = 2'd1,
        ACT_STEP = 2'd2
    } seq_act_e;

endpackage

// File: rtl/burst_load_ctrl.sv
// Module: burst_load_ctrl
// Decides, each cycle, whether the sequencer loads, steps or holds.
// Assumes: the strobes and adv are synchronous to clk. A load outranks adv.
module burst_load_ctrl
    import burst_seq_pkg::*;
(
    input  logic     ld_a,
    input  logic     ld_b,
    input  logic     adv,
    output seq_act_e act
);

    // Priority select: either strobe, then advance, else hold.
    always_comb begin
        if (ld_a || ld_b) begin
            act = ACT_LOAD;
        end else if (adv) begin
            act = ACT_STEP;
        end else begin
            act = ACT_HOLD;
        end
    end

endmodule

// File: rtl/burst_beat_cnt.sv
// Module: burst_beat_cnt
// Keeps the loaded start bits and the count of beats taken since the load.
// Assumes: BEAT_W is small (the beat count wraps modulo 2**BEAT_W).
module burst_beat_cnt
    import burst_seq_pkg::*;
#(
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  seq_act_e          act,
    input  logic [BEAT_W-1:0] load_lo,
    output logic [BEAT_W-1:0] start_q,
    output logic [BEAT_W-1:0] beat_q,
    output logic [BEAT_W-1:0] beat_nxt
);

    localparam logic [BEAT_W-1:0] BEAT_ONE = BEAT_W'(1);

    // Count of the beat that the next step would reach.
    assign beat_nxt = beat_q + BEAT_ONE;

    // Start bits and beat count: reset, capture on load, count on step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
            beat_q  <= '0;
        end else begin
            case (act)
                ACT_LOAD: begin
                    start_q <= load_lo;
                    beat_q  <= '0;
                end
                ACT_STEP: beat_q <= beat_nxt;
                default:  ;
            endcase
        end
    end

    // A step moves the count forward by exactly one, modulo the burst length (R6).
    p_beat_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_STEP) |=> (beat_q == $past(beat_q) + BEAT_ONE));

    // A load clears the beat count (R7).
    p_load_clears_beat_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_LOAD) |=> (beat_q == '0));

endmodule

// File: rtl/burst_order_map.sv
// Module: burst_order_map
// Maps the start bits and a beat count to low address bits in linear or
// interleaved order.
// Assumes: purely combinational. The mode is constant over a burst.
module burst_order_map #(
    parameter int BEAT_W = 2
) (
    input  logic [BEAT_W-1:0] start_lo,
    input  logic [BEAT_W-1:0] beat,
    input  logic              order_lin,
    output logic [BEAT_W-1:0] lo_out
);

    logic [BEAT_W-1:0] lin_lo;
    logic [BEAT_W-1:0] ilv_lo;

    // Linear order: modular add of the beat count to the start bits.
    assign lin_lo = start_lo + beat;

    // Interleaved order: bitwise XOR, one gate per address bit.
    for (genvar gi = 0; gi < BEAT_W; gi++) begin : g_ilv
        assign ilv_lo[gi] = start_lo[gi] ^ beat[gi];
    end

    // Order select: mode high picks linear, low picks interleaved.
    assign lo_out = order_lin ? lin_lo : ilv_lo;

endmodule

// File: rtl/burst_addr_seq.sv
// Module: burst_addr_seq
// Top of the burst address sequencer. Loads an external address on either
// strobe, steps the low BEAT_W bits on adv in linear or interleaved order,
// and otherwise holds.
// Assumes: synchronous active-low reset; order_lin is stable during a burst.
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic              ld_a,
    input  logic              ld_b,
    input  logic              adv,
    input  logic              order_lin,
    output logic [ADDR_W-1:0] burst_addr
);

    localparam int HI_W = ADDR_W - BEAT_W;

    seq_act_e          act;
    logic [BEAT_W-1:0] start_q;
    logic [BEAT_W-1:0] beat_q;
    logic [BEAT_W-1:0] beat_nxt;
    logic [BEAT_W-1:0] lo_nxt;
    logic [ADDR_W-1:0] addr_q;

    burst_load_ctrl u_ctrl (
        .ld_a (ld_a),
        .ld_b (ld_b),
        .adv  (adv),
        .act  (act)
    );

    burst_beat_cnt #(.BEAT_W(BEAT_W)) u_beat (
        .clk      (clk),
        .rst_n    (rst_n),
        .act      (act),
        .load_lo  (ext_addr[BEAT_W-1:0]),
        .start_q  (start_q),
        .beat_q   (beat_q),
        .beat_nxt (beat_nxt)
    );

    burst_order_map #(.BEAT_W(BEAT_W)) u_map (
        .start_lo  (start_q),
        .beat      (beat_nxt),
        .order_lin (order_lin),
        .lo_out    (lo_nxt)
    );

    // Address register: reset, load whole address, step low bits, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else begin
            case (act)
                ACT_LOAD: addr_q <= ext_addr;
                ACT_STEP: addr_q[BEAT_W-1:0] <= lo_nxt;
                default:  ;
            endcase
        end
    end

    assign burst_addr = addr_q;

    // A strobe captures the offered address (R2, R7).
    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_a || ld_b) |=> (burst_addr == $past(ext_addr)));

    // Upper bits are untouched by a step (R3).
    p_upper_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_a && !ld_b && adv) |=> (burst_addr[ADDR_W-1:BEAT_W] == $past(burst_addr[ADDR_W-1:BEAT_W])));

    // Linear step: low bits minus start equal the beat count (R4).
    p_linear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_a && !ld_b && adv && order_lin) |=> (BEAT_W'(burst_addr[BEAT_W-1:0] - start_q) == beat_q));

    // Interleaved step: low bits XOR start equal the beat count (R5).
    p_interleave_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_a && !ld_b && adv && !order_lin) |=> ((burst_addr[BEAT_W-1:0] ^ start_q) == beat_q));

    // Idle cycle keeps the address (R8).
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_a && !ld_b && !adv) |=> $stable(burst_addr));

    // Reset clears the address (R1).
    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (burst_addr == '0));

    // Upper-field width must be non-negative.
    initial begin
        assert (HI_W >= 0) else $error("ADDR_W smaller than BEAT_W");
    end

endmodule

// File: tb/burst_addr_seq_bench.sv
module burst_addr_seq_bench;

    localparam int AW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] ext_addr = '0;
    logic          ld_a = 1'b0;
    logic          ld_b = 1'b0;
    logic          adv = 1'b0;
    logic          order_lin = 1'b0;
    logic [AW-1:0] burst_addr;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    burst_addr_seq #(.ADDR_W(AW), .BEAT_W(2)) u_burst_addr_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .ext_addr   (ext_addr),
        .ld_a       (ld_a),
        .ld_b       (ld_b),
        .adv        (adv),
        .order_lin  (order_lin),
        .burst_addr (burst_addr)
    );

    always #10 clk = ~clk;   // 50 MHz

    task automatic check(input string req, input logic [AW-1:0] exp);
        n_chk++;
        if (burst_addr !== exp) begin
            n_fail++;
            $display("FAIL %s: burst_addr=%h expected=%h", req, burst_addr, exp);
        end
    endtask

    // Drive one cycle at the falling edge, then sample just after the rising edge.
    task automatic cyc(input logic a, input logic b, input logic s, input logic [AW-1:0] ad);
        @(negedge clk);
        ld_a = a; ld_b = b; adv = s; ext_addr = ad;
        @(posedge clk);
        #2;
    endtask

    function automatic logic [AW-1:0] expect_addr(input logic [AW-1:0] base, input bit lin, input int k);
        logic [1:0] s;
        logic [1:0] lo;
        s  = base[1:0];
        lo = lin ? 2'((int'(s) + k) % 4) : 2'(s ^ 2'(k % 4));
        return {base[AW-1:2], lo};
    endfunction

    initial begin
        logic [AW-1:0] base;
        repeat (2) @(posedge clk);
        #2;
        check("R1", '0);
        @(negedge clk);
        rst_n = 1'b1;

        // Sweep: order x start x upper pattern x strobe choice.
        for (int m = 0; m < 2; m++) begin
            for (int st = 0; st < 4; st++) begin
                for (int up = 0; up < 2; up++) begin
                    @(negedge clk);
                    order_lin = m[0];
                    base = {(up == 0) ? 8'hA5 : 8'h3C, 2'(st)};
                    cyc(up == 0, up == 1, 1'b0, base);
                    check("R2", base);
                    for (int k = 1; k <= 6; k++) begin
                        cyc(1'b0, 1'b0, 1'b1, '1);
                        if (m == 1) check("R4 R3", expect_addr(base, 1'b1, k));
                        else        check("R5 R3", expect_addr(base, 1'b0, k));
                        if (k == 4) check("R6", base);
                        if (k == 2) begin
                            cyc(1'b0, 1'b0, 1'b0, '0);
                            check("R8", expect_addr(base, m[0], k));
                        end
                    end
                end
            end
        end

        // Priority: strobe with advance mid-burst loads and restarts.
        order_lin = 1'b0;
        cyc(1'b1, 1'b0, 1'b0, 10'h101);
        cyc(1'b0, 1'b0, 1'b1, '0);
        check("R5", 10'h100);
        cyc(1'b0, 1'b1, 1'b1, 10'h2F2);
        check("R7", 10'h2F2);
        cyc(1'b0, 1'b0, 1'b1, '0);
        check("R7", 10'h2F3);
        cyc(1'b1, 1'b1, 1'b1, 10'h013);
        check("R7", 10'h013);

        // Back-to-back loads, one per cycle.
        for (int i = 0; i < 8; i++) begin
            cyc(i[0], ~i[0], 1'b0, AW'(i * 37 + 5));
            check("R9", AW'(i * 37 + 5));
        end

        // Reset after activity.
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #2;
        check("R1", '0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule